// File: doc/BRIEF.md
# Paged Memory Byte Read Port

This block lets a host pull a stream of bytes out of a memory that is addressed one bit at a time. The memory is organised as pages of 64 bits. The host opens a transfer with chip select low and one of two command codes. A start code loads the bit read position from a page number. A resume code carries on from where the previous transfer left off. The block then fetches bits one per cycle from a synchronous single-bit memory port. It packs every eight bits into a byte and offers that byte on a valid/take handshake, in place of a serial reply shifter. The next byte is assembled while the current one waits, so a host that is slower than nine cycles per byte never waits. Raising chip select ends the transfer at any point.

The FSM has three states. In ST_IDLE the block waits for a command. In ST_FILL it issues memory reads and assembles a byte. In ST_READY it holds a full byte while the output slot is still occupied. The transitions are:
- ST_IDLE to ST_FILL on an accepted command (the load transition).
- ST_FILL to ST_READY when a byte is complete but the output slot is busy (the stall transition).
- ST_READY to ST_FILL when the host takes the held byte (the release transition).
- ST_FILL or ST_READY to ST_IDLE when chip select rises (the abort transition).

When the slot is free, a completed byte moves to the output and the FSM stays in ST_FILL.

Top module: `pmr_read_port`

## Requirements
- R1: After reset, `byte_valid` and `mem_rd_en` are low. The resume position is bit 0.
- R2: The block accepts a command on an edge where it is idle, `cs_n` is 0 and `cmd_valid` is 1. Code 8'h67 sets the read position to `cmd_page` × 64. The bytes that follow carry the memory bits from that position onward.
- R3: Bytes are packed MSB first. The first bit read of a byte lands in `byte_data[7]` and the eighth lands in `byte_data[0]`.
- R4: Each memory read is one bit past the previous read in the same transfer. Successive bytes run on across page boundaries without a gap.
- R5: The read position wraps from the last bit of memory (PAGES × 64 − 1) to bit 0.
- R6: `byte_valid` first rises on the tenth rising edge after the edge that accepted a command.
- R7: While `byte_valid` is 1 and `byte_take` is 0, `byte_data` stays unchanged. Across any host stall, no byte is lost or repeated.
- R8: While `cs_n` is 1, no memory reads are issued. `byte_valid` is 0 after the first edge with `cs_n` at 1, and partly assembled or untaken bytes are discarded.
- R9: Code 8'h69 resumes at the bit just after the last byte the host took, without using `cmd_page`.
- R10: These commands have no effect: codes other than 8'h67 and 8'h69, commands given while `cs_n` is 1, and commands given while a transfer is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low; high ends a transfer |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code (8'h67 start, 8'h69 resume) |
| cmd_page | input | PAGE_W | Start page number for the start code |
| byte_valid | output | 1 | A byte is offered to the host |
| byte_data | output | 8 | Offered byte, first bit read in bit 7 |
| byte_take | input | 1 | Host takes the offered byte this cycle |
| mem_rd_en | output | 1 | Read one bit from memory |
| mem_addr | output | ADDR_W | Bit address of the read |
| mem_rd_bit | input | 1 | Bit returned one cycle after `mem_rd_en` |

## Verification
The assertions assume two things about the inputs. The memory returns its bit on the cycle after each read. The host holds `cs_n` high for at least one edge between transfers. The bench memory is a registered model driven by a pure function of the address, so the one-cycle return always holds. Every transfer in the random and directed sequences ends by holding `cs_n` high for two edges. The host pulses `byte_take` only while a byte is offered and only between chip-select edges. Random stalls run from zero to fifteen cycles, and the start pages include the last page of memory.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_READY
    } pmr_state_t;
endpackage

// File: rtl/pmr_bit_counter.sv
module pmr_bit_counter #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              resume_en,
    input  logic              fetch_step,
    input  logic              commit_step,
    output logic [ADDR_W-1:0] fetch_addr
);
    import pmr_pkg::*;

    logic [ADDR_W-1:0] commit_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fetch_addr  <= '0;
            commit_addr <= '0;
        end else begin
            if (load_en) begin
                fetch_addr  <= load_val;
                commit_addr <= load_val;
            end else begin
                if (resume_en)
                    fetch_addr <= commit_addr;
                else if (fetch_step)
                    fetch_addr <= fetch_addr + 1'b1;
                if (commit_step)
                    commit_addr <= commit_addr + ADDR_W'(BYTE_W);
            end
        end
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_step && $past(fetch_step)) |-> (fetch_addr == $past(fetch_addr) + 1'b1)); // R4
endmodule

// File: rtl/pmr_byte_packer.sv
module pmr_byte_packer (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic                      issue,
    input  logic                      bit_in,
    output logic                      room,
    output logic                      full,
    output logic [pmr_pkg::BYTE_W-1:0] data
);
    import pmr_pkg::*;

    logic [CNT_W-1:0] issue_cnt;
    logic [CNT_W-1:0] recv_cnt;
    logic             pend_q;

    assign room = (issue_cnt < CNT_W'(BYTE_W));
    assign full = (recv_cnt == CNT_W'(BYTE_W));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            issue_cnt <= '0;
            recv_cnt  <= '0;
            pend_q    <= 1'b0;
            data      <= '0;
        end else if (flush) begin
            issue_cnt <= '0;
            recv_cnt  <= '0;
            pend_q    <= 1'b0;
        end else begin
            pend_q <= issue;
            if (issue)
                issue_cnt <= issue_cnt + 1'b1;
            if (pend_q) begin
                data     <= {data[BYTE_W-2:0], bit_in};
                recv_cnt <= recv_cnt + 1'b1;
            end
        end
    end

    AST_RECV_LE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        recv_cnt <= issue_cnt); // R4
endmodule

// File: rtl/pmr_read_port.sv
module pmr_read_port #(
    parameter int         PAGES      = 32,
    parameter int         PAGE_BITS  = 64,
    parameter logic [7:0] START_CODE = 8'h67,
    parameter logic [7:0] CONT_CODE  = 8'h69,
    localparam int        PAGE_W     = $clog2(PAGES),
    localparam int        SHIFT_W    = $clog2(PAGE_BITS),
    localparam int        ADDR_W     = PAGE_W + SHIFT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_code,
    input  logic [PAGE_W-1:0] cmd_page,
    output logic              byte_valid,
    output logic [7:0]        byte_data,
    input  logic              byte_take,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rd_bit
);
    import pmr_pkg::*;

    pmr_state_t state, state_nx;

    logic is_start, is_cont, accept;
    logic slot_free, move, commit;
    logic pk_room, pk_full, pk_flush;
    logic [BYTE_W-1:0] pk_data;

    assign is_start  = (cmd_code == START_CODE);
    assign is_cont   = (cmd_code == CONT_CODE);
    assign accept    = (state == ST_IDLE) && cmd_valid && !cs_n && (is_start || is_cont);
    assign slot_free = !byte_valid || byte_take;
    assign move      = !cs_n && pk_full && slot_free && (state != ST_IDLE);
    assign commit    = !cs_n && byte_valid && byte_take;
    assign mem_rd_en = !cs_n && (state == ST_FILL) && pk_room;
    assign pk_flush  = cs_n || move;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = ST_FILL;
            ST_FILL: begin
                if (cs_n)                       state_nx = ST_IDLE;
                else if (pk_full && !slot_free) state_nx = ST_READY;
            end
            ST_READY: begin
                if (cs_n)           state_nx = ST_IDLE;
                else if (slot_free) state_nx = ST_FILL;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_valid <= 1'b0;
            byte_data  <= '0;
        end else if (cs_n) begin
            byte_valid <= 1'b0;
        end else if (move) begin
            byte_valid <= 1'b1;
            byte_data  <= pk_data;
        end else if (byte_take) begin
            byte_valid <= 1'b0;
        end
    end

    pmr_bit_counter #(.ADDR_W(ADDR_W)) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_en     (accept && is_start),
        .load_val    ({cmd_page, {SHIFT_W{1'b0}}}),
        .resume_en   (accept && is_cont),
        .fetch_step  (mem_rd_en),
        .commit_step (commit),
        .fetch_addr  (mem_addr)
    );

    pmr_byte_packer u_pack (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (pk_flush),
        .issue  (mem_rd_en),
        .bit_in (mem_rd_bit),
        .room   (pk_room),
        .full   (pk_full),
        .data   (pk_data)
    );

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !byte_take && !cs_n) |=> (byte_valid && $stable(byte_data))); // R7
    AST_CS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !byte_valid); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !byte_valid); // R8
endmodule

// File: tb/tb_pmr_read_port.sv
module tb_pmr_read_port;
    localparam int PAGES  = 32;
    localparam int PAGE_W = 5;
    localparam int ADDR_W = 11;
    localparam int MEMSZ  = PAGES * 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic cmd_valid = 1'b0;
    logic [7:0] cmd_code = '0;
    logic [PAGE_W-1:0] cmd_page = '0;
    logic byte_valid;
    logic [7:0] byte_data;
    logic byte_take = 1'b0;
    logic mem_rd_en;
    logic [ADDR_W-1:0] mem_addr;
    logic mem_q = 1'b0;

    int checks = 0;
    int errors = 0;
    int ptr = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pmr_read_port #(.PAGES(PAGES)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .cmd_page(cmd_page), .byte_valid(byte_valid),
        .byte_data(byte_data), .byte_take(byte_take), .mem_rd_en(mem_rd_en),
        .mem_addr(mem_addr), .mem_rd_bit(mem_q)
    );

    function automatic logic mem_fn(int a);
        int unsigned x;
        x = (int'(a) + 7) * 32'h9E3779B1;
        return x[17] ^ x[6];
    endfunction

    always_ff @(posedge clk) if (mem_rd_en) mem_q <= mem_fn(int'(mem_addr));

    function automatic logic [7:0] exp_byte(int a);
        logic [7:0] b;
        for (int k = 0; k < 8; k++) b[7-k] = mem_fn((a + k) % MEMSZ);
        return b;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_cmd(logic [7:0] code, int page);
        @(negedge clk);
        cs_n = 1'b0; cmd_valid = 1'b1; cmd_code = code; cmd_page = PAGE_W'(page);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic get_byte(int stall, string req);
        int waited = 0;
        while (!byte_valid && waited < 40) begin @(negedge clk); waited++; end
        chk(byte_valid && byte_data == exp_byte(ptr), req, int'(byte_data), int'(exp_byte(ptr)));
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            if (!(byte_valid && byte_data == exp_byte(ptr)))
                chk(1'b0, "R7 held byte", int'(byte_data), int'(exp_byte(ptr)));
        end
        byte_take = 1'b1;
        @(negedge clk);
        byte_take = 1'b0;
        ptr = (ptr + 8) % MEMSZ;
    endtask

    task automatic end_xfer();
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
        chk(!byte_valid && !mem_rd_en, "R8 cs high clears", int'(byte_valid), 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int cnt, bad, pg, n;
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        chk(!byte_valid && !mem_rd_en, "R1 reset outputs", int'(byte_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!byte_valid && !mem_rd_en, "R1 after reset", int'(mem_rd_en), 0);

        // R1: resume right after reset starts at bit 0
        ptr = 0;
        send_cmd(8'h69, 9);
        get_byte(0, "R1 resume from zero");
        end_xfer();

        // R6 latency, R2/R3 start page content
        send_cmd(8'h67, 4);
        ptr = 4 * 64;
        cnt = 0;
        while (!byte_valid && cnt < 30) begin @(negedge clk); cnt++; end
        chk(cnt == 10, "R6 first byte latency", cnt, 10);
        chk(byte_data == exp_byte(ptr), "R3 MSB first", int'(byte_data), int'(exp_byte(ptr)));
        for (int i = 0; i < 10; i++) get_byte(i % 3, "R4 across page boundary");
        end_xfer();

        // R5 wrap from last page
        send_cmd(8'h67, PAGES - 1);
        ptr = (PAGES - 1) * 64;
        for (int i = 0; i < 10; i++) get_byte(1, "R5 wrap to zero");
        end_xfer();

        // R10 command while active is ignored
        send_cmd(8'h67, 2);
        ptr = 2 * 64;
        get_byte(0, "R2 start page 2");
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 8'h67; cmd_page = 5'd20;
        @(negedge clk);
        cmd_valid = 1'b0;
        get_byte(2, "R10 active command ignored");
        get_byte(0, "R10 active command ignored");
        end_xfer();

        // R8 discard partial, R9 resume after last taken byte
        send_cmd(8'h67, 7);
        ptr = 7 * 64;
        get_byte(0, "R2 start page 7");
        get_byte(0, "R2 start page 7");
        repeat (4) @(negedge clk);
        end_xfer();
        send_cmd(8'h69, 0);
        get_byte(0, "R9 resume point");
        get_byte(5, "R9 resume point");
        end_xfer();

        // R10 unknown code
        send_cmd(8'h55, 3);
        bad = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (byte_valid || mem_rd_en) bad++; end
        chk(bad == 0, "R10 unknown code", bad, 0);
        end_xfer();

        // R10 command with cs_n high
        @(negedge clk);
        cs_n = 1'b1; cmd_valid = 1'b1; cmd_code = 8'h67; cmd_page = 5'd1;
        @(negedge clk);
        cmd_valid = 1'b0;
        bad = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (byte_valid || mem_rd_en) bad++; end
        chk(bad == 0, "R10 command while deselected", bad, 0);
        // state unchanged: resume still starts after last taken byte
        send_cmd(8'h69, 1);
        get_byte(0, "R10 pointer untouched");
        end_xfer();

        // random transfers
        for (int t = 0; t < 25; t++) begin
            pg = int'($urandom_range(0, PAGES - 1));
            if ($urandom_range(0, 3) == 0) begin
                send_cmd(8'h69, pg);
            end else begin
                send_cmd(8'h67, pg);
                ptr = pg * 64;
            end
            n = int'($urandom_range(1, 12));
            for (int i = 0; i < n; i++) get_byte(int'($urandom_range(0, 15)), "R7 random stream");
            repeat ($urandom_range(0, 12)) @(negedge clk);
            end_xfer();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule